// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive half of an I2C target. It watches the open-drain clock and data lines through a synchronizer running on a much faster system clock. It tracks START and STOP to keep a bus-busy indication. After each START it collects the first byte and compares its upper seven bits against a programmed own address. If they match and the direction bit asks for a write, it acknowledges and then receives data bytes most significant bit first.

Each accepted byte, including the address byte, is acknowledged by pulling data low through the ninth clock. When the acknowledge begins, the byte is copied to a readable data register and a sticky receive flag rises. The flag can raise an interrupt. From the falling edge of the ninth clock the block holds the clock line low. A host read pulse releases it, and that same release starts the next byte. A clear pulse drops the flag.

A byte that does not match, or a read request, is answered with no acknowledge. The block then stays silent until the next START or STOP. Clearing the enable input returns the block to idle and releases both lines.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, both line drivers are released and bus_busy, rx_flag and irq are 0.
- R2: A START (SDA falling while SCL is high) sets bus_busy to 1. This holds for a repeated START too.
- R3: A STOP (SDA rising while SCL is high) clears bus_busy to 0.
- R4: If the first byte after START carries the own address in bits 7..1 and 0 in bit 0 (write), SDA is held low during the ninth clock. rx_flag is set and rd_data shows that whole byte.
- R5: If the address differs or bit 0 is 1, SDA stays released on the ninth clock and rx_flag stays 0. SCL is not held. Later bytes are not acknowledged until the next START or STOP.
- R6: From the fall of the ninth clock of an acknowledged byte, SCL is held low until a host_rd pulse. Clearing the flag alone does not release it.
- R7: Data bytes after an accepted address are taken MSB first. Each is acknowledged and appears in rd_data with rx_flag set.
- R8: rx_flag stays 1 until a host_clr pulse, which makes it 0.
- R9: irq is 1 exactly while rx_flag is 1 and cfg_irq_en is 1.
- R10: With cfg_en at 0, neither line is driven, no byte is acknowledged and bus_busy stays 0.
- R11: A repeated START after an accepted byte restarts address matching. A matching address is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_en | input | 1 | Receiver enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_own_addr | input | DATA_W-1 | Own 7-bit address |
| host_clr | input | 1 | One-cycle pulse, clears rx_flag |
| host_rd | input | 1 | One-cycle pulse, data read; releases SCL |
| rd_data | output | DATA_W | Last acknowledged byte |
| bus_busy | output | 1 | Bus busy between START and STOP |
| rx_flag | output | 1 | Sticky receive-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the stretch hold. In it, the master has already let go of SCL, and only the block's own pull keeps the line low. A plain sequential master would block on that held clock forever. So the bench forks the next bus action, the next byte, a STOP or a repeated START, against a host process. That process watches the held line, checks the flag, data and interrupt, clears the flag, and only then reads. This shows that the clear leaves SCL held and that the read releases it. The repeated START issued out of a held clock and the traffic ignored after a rejected address are driven the same way.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD,
    ST_IGNORE
  } rx_state_t;
endpackage

// File: rtl/i2c_rx_sync.sv
// Line synchronizer with edge and bus-condition detection.
module i2c_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int W = STAGES + 1;

  logic [W-1:0] scl_q;
  logic [W-1:0] sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[W-2:0], scl_i};
      sda_q <= {sda_q[W-2:0], sda_i};
    end
  end

  // index W-2 is the synchronized value, W-1 the previous one
  assign sda_s     = sda_q[W-2];
  assign scl_rise  = scl_q[W-2] & ~scl_q[W-1];
  assign scl_fall  = ~scl_q[W-2] & scl_q[W-1];
  assign start_det = scl_q[W-2] & scl_q[W-1] & sda_q[W-1] & ~sda_q[W-2];
  assign stop_det  = scl_q[W-2] & scl_q[W-1] & ~sda_q[W-1] & sda_q[W-2];
endmodule

// File: rtl/i2c_rx_fsm.sv
// Bit-level receive sequencer: address match, ack, stretch.
module i2c_rx_fsm
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rd_release,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              addr_phase;
  logic              addr_hit;

  assign addr_hit = (shreg[DATA_W-1:1] == own_addr) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      addr_phase <= 1'b0;
      busy       <= 1'b0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      byte_done  <= 1'b0;
      byte_val   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (start_det) begin
        busy       <= 1'b1;
        state      <= ST_SHIFT;
        bit_cnt    <= '0;
        addr_phase <= 1'b1;
        scl_oe     <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_det) begin
        busy   <= 1'b0;
        state  <= ST_IDLE;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_SHIFT: begin
            if (scl_rise && bit_cnt != LAST) begin
              shreg   <= {shreg[DATA_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST) begin
              if (!addr_phase || addr_hit) begin
                sda_oe     <= 1'b1;
                byte_done  <= 1'b1;
                byte_val   <= shreg;
                addr_phase <= 1'b0;
                state      <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              scl_oe <= 1'b1;
              state  <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (rd_release) begin
              scl_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_SHIFT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rx_host.sv
// Host-side flag, data holding register and interrupt.
module i2c_rx_host #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              clr,
  input  logic              irq_en,
  output logic              flag,
  output logic [DATA_W-1:0] data,
  output logic              irq
);
  logic flag_n;

  always_comb begin
    flag_n = flag;
    if (clr)       flag_n = 1'b0;
    if (byte_done) flag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      data <= '0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n & irq_en;
      if (byte_done) data <= byte_val;
    end
  end
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              cfg_en,
  input  logic              cfg_irq_en,
  input  logic [DATA_W-2:0] cfg_own_addr,
  input  logic              host_clr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_busy,
  output logic              rx_flag,
  output logic              irq
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .en(cfg_en), .own_addr(cfg_own_addr),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_release(host_rd),
    .busy(bus_busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  i2c_rx_host #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_val(byte_val),
    .clr(host_clr), .irq_en(cfg_irq_en),
    .flag(rx_flag), .data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/i2c_rx_slave_chk.sv
module i2c_rx_slave_chk (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic cfg_irq_en,
  input logic host_clr,
  input logic host_rd,
  input logic scl_oe,
  input logic sda_oe,
  input logic bus_busy,
  input logic rx_flag,
  input logic irq
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!scl_oe && !sda_oe && !bus_busy && !rx_flag && !irq)); // R1

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rx_flag && $past(cfg_irq_en))); // R9

  AST_STRETCH_HELD: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !host_rd && cfg_en) |=> scl_oe); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !host_clr) |=> rx_flag); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!scl_oe && !sda_oe && !bus_busy)); // R10
endmodule

bind i2c_rx_slave i2c_rx_slave_chk u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
  .host_clr(host_clr), .host_rd(host_rd), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .bus_busy(bus_busy), .rx_flag(rx_flag), .irq(irq)
);

// File: tb/i2c_rx_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_rx_slave_tb_top;
  localparam int HALF = 10;
  localparam int QTR  = 5;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic cfg_en = 1'b0, cfg_irq_en = 1'b0;
  logic host_clr = 1'b0, host_rd = 1'b0;
  logic scl_oe, sda_oe, bus_busy, rx_flag, irq;
  logic [7:0] rd_data;
  logic scl_line, sda_line;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_rx_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_en(cfg_en),
    .cfg_irq_en(cfg_irq_en), .cfg_own_addr(OWN), .host_clr(host_clr),
    .host_rd(host_rd), .rd_data(rd_data), .bus_busy(bus_busy),
    .rx_flag(rx_flag), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0;
    cyc(QTR);
    m_scl_low = 1'b0;
    wait (scl_line === 1'b1);
    cyc(HALF);
    m_sda_low = 1'b1;
    cyc(HALF);
    m_scl_low = 1'b1;
    cyc(QTR);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1;
    cyc(QTR);
    m_scl_low = 1'b0;
    wait (scl_line === 1'b1);
    cyc(HALF);
    m_sda_low = 1'b0;
    cyc(HALF);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_sda_low = ~b;
    cyc(QTR);
    m_scl_low = 1'b0;
    wait (scl_line === 1'b1);
    cyc(HALF);
    seen = sda_line;
    m_scl_low = 1'b1;
    cyc(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = ~s;
  endtask

  // host side while the block stretches: check, clear, read
  task automatic host_service(input logic [7:0] exp, input logic exp_irq);
    cyc(30);
    check("R6 scl held", scl_line, 1'b0);
    check("R8 flag sticky", rx_flag, 1'b1);
    check("R7 rd_data", rd_data, exp);
    check("R9 irq", irq, exp_irq);
    host_clr = 1'b1; cyc(1); host_clr = 1'b0;
    cyc(2);
    check("R8 flag cleared", rx_flag, 1'b0);
    check("R9 irq after clear", irq, 1'b0);
    check("R6 held after clear", scl_line, 1'b0);
    host_rd = 1'b1; cyc(1); host_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic ak;
    cyc(5);
    rst = 1'b0;
    cyc(2);
    check("R1 scl_oe", scl_oe, 1'b0);
    check("R1 sda_oe", sda_oe, 1'b0);
    check("R1 busy", bus_busy, 1'b0);
    check("R1 flag", rx_flag, 1'b0);
    check("R1 irq", irq, 1'b0);

    // accepted address, two data bytes, stop
    cfg_en = 1'b1; cfg_irq_en = 1'b1;
    cyc(4);
    bus_start();
    check("R2 busy on start", bus_busy, 1'b1);
    send_byte({OWN, 1'b0}, ak);
    check("R4 address ack", ak, 1'b1);
    check("R4 flag", rx_flag, 1'b1);
    check("R4 rd_data addr", rd_data, {OWN, 1'b0});
    fork
      send_byte(8'hA5, ak);
      host_service({OWN, 1'b0}, 1'b1);
    join
    check("R7 data ack A5", ak, 1'b1);
    fork
      send_byte(8'h3C, ak);
      host_service(8'hA5, 1'b1);
    join
    check("R7 data ack 3C", ak, 1'b1);
    fork
      bus_stop();
      host_service(8'h3C, 1'b1);
    join
    cyc(6);
    check("R3 busy after stop", bus_busy, 1'b0);
    check("R6 released after read", scl_line, 1'b1);

    // wrong address: nack, no stretch, later byte ignored
    cfg_irq_en = 1'b0;
    bus_start();
    send_byte(8'h50, ak);
    check("R5 mismatch nack", ak, 1'b0);
    m_scl_low = 1'b0;
    cyc(30);
    check("R5 no stretch", scl_line, 1'b1);
    check("R5 no flag", rx_flag, 1'b0);
    m_scl_low = 1'b1;
    cyc(QTR);
    send_byte({OWN, 1'b0}, ak);
    check("R5 ignored byte nack", ak, 1'b0);
    check("R5 flag after ignored", rx_flag, 1'b0);
    bus_stop();
    cyc(6);
    check("R3 busy after stop 2", bus_busy, 1'b0);

    // read-direction address: nack
    bus_start();
    send_byte({OWN, 1'b1}, ak);
    check("R5 read bit nack", ak, 1'b0);
    check("R5 read bit no flag", rx_flag, 1'b0);
    bus_stop();

    // irq disabled, repeated start
    bus_start();
    send_byte({OWN, 1'b0}, ak);
    check("R4 ack again", ak, 1'b1);
    fork
      bus_start();
      host_service({OWN, 1'b0}, 1'b0);
    join
    check("R2 busy after repeated start", bus_busy, 1'b1);
    send_byte({OWN, 1'b0}, ak);
    check("R11 ack after repeated start", ak, 1'b1);
    fork
      bus_stop();
      host_service({OWN, 1'b0}, 1'b0);
    join
    cyc(6);
    check("R3 busy final", bus_busy, 1'b0);

    // disabled block
    cfg_en = 1'b0;
    cyc(2);
    bus_start();
    check("R10 busy stays 0", bus_busy, 1'b0);
    send_byte({OWN, 1'b0}, ak);
    check("R10 no ack", ak, 1'b0);
    check("R10 no flag", rx_flag, 1'b0);
    m_scl_low = 1'b0;
    cyc(10);
    check("R10 scl free", scl_line, 1'b1);
    m_scl_low = 1'b1;
    cyc(QTR);
    bus_stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule